// File: doc/BRIEF.md
# Test Access Port with Word-Memory Bus Bridge

This block is a serial test access port driven by the four usual boundary-scan pins (test clock, mode select, data in, data out) plus an optional asynchronous port reset. A sixteen-state controller walks the standard state graph. A 4-bit instruction register selects which data register sits between data-in and data-out. Besides an identification word and a one-bit bypass stage, three instructions give a debug host access to system memory. The first loads a 30-bit word address. The second streams words out of memory. The third streams words out while it replaces each one with the word shifted in.

Memory traffic runs on a classic single-cycle-handshake bus master clocked by the system clock. Each completed data shift on a memory instruction raises a toggle request. The toggle crosses into the system domain through a synchronizer. The bus master then performs an optional write followed by a read that prefetches the next word. A second toggle carries the acknowledge back into the test-clock domain. The word address advances after every data access, so back-to-back shifts walk through consecutive words. The host must leave a few idle test clocks between an update and the next capture.

Top module: `jtag_mem_bridge`

## Requirements
- R1: After the port reset is released, data-out is 0 and no bus cycle is active. Data-out stays 0 whenever the controller is in neither shift state.
- R2: After reset the selected instruction is the identification code 0001. A 32-bit data shift then returns 0x000018FF, on every repeat, even while the system domain is held in reset.
- R3: An instruction shift returns the capture pattern 0001, least significant bit first.
- R4: Five test clocks with mode select high reach the reset state from any state and restore the identification instruction.
- R5: Code 1111 selects a 1-bit bypass stage that captures 0. Any code other than 0001, 0101, 0110 and 0111 behaves the same way. Data-out is then data-in delayed by one test clock.
- R6: Code 0101 selects the 30-bit address register. Its capture value is the current word address, and its update loads a new address and reads the word stored there.
- R7: Code 0111 selects a 32-bit register that shifts out the word stored at the current address. The word shifted in is written to that same address.
- R8: After each update of the read or read-write register the word address increases by one, wrapping from 0x3FFFFFFF to 0. The bus read that follows each update targets that new address.
- R9: Code 0110 shifts out the stored word. The bits shifted in cause no bus write.
- R10: A bus request holds strobe only inside an active cycle, keeps address and direction steady until acknowledged, and completes before the next capture.
- R11: All registers shift least significant bit first. Data-in is sampled on the rising test-clock edge. Data-out changes only on the falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous port reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling test-clock edge |
| sys_clk | input | 1 | System clock for the bus master |
| sys_rst_n | input | 1 | System-domain reset, active low |
| wb_cyc | output | 1 | Bus cycle active |
| wb_stb | output | 1 | Bus strobe |
| wb_we | output | 1 | Bus write enable |
| wb_adr | output | 30 | Bus word address |
| wb_dat_w | output | 32 | Bus write data |
| wb_sel | output | 4 | Byte selects, all set |
| wb_dat_r | input | 32 | Bus read data |
| wb_ack | input | 1 | Bus acknowledge |

## Verification
A single read-write update makes the bus write of the new word and the prefetch read of the following word fall back to back. The write acknowledge and the start of the read share one system clock. Swap shifts over adjacent addresses provoke this, under a slave whose wait states rotate through zero, one and two cycles. The bench queues every expected write and read address and its data, and compares each acknowledged transfer against the head of the queue. The next shift then has to return exactly the word the write just left behind.

// File: rtl/tapbr_pkg.sv
package tapbr_pkg;

   typedef enum logic [3:0] {
      TS_RESET, TS_IDLE, TS_SEL_DR, TS_CAP_DR, TS_SH_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR,
      TS_UPD_DR, TS_SEL_IR, TS_CAP_IR, TS_SH_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
   } tap_state_t;

   typedef enum logic [2:0] {
      DR_BYPASS, DR_IDENT, DR_ADDR, DR_READ, DR_SWAP
   } dr_sel_t;

   typedef enum logic [1:0] {
      BM_IDLE, BM_WRITE, BM_READ
   } bm_state_t;

   function automatic tap_state_t tap_next(tap_state_t s, logic m);
      tap_state_t n;
      case (s)
         TS_RESET:  n = m ? TS_RESET   : TS_IDLE;
         TS_IDLE:   n = m ? TS_SEL_DR  : TS_IDLE;
         TS_SEL_DR: n = m ? TS_SEL_IR  : TS_CAP_DR;
         TS_CAP_DR: n = m ? TS_EX1_DR  : TS_SH_DR;
         TS_SH_DR:  n = m ? TS_EX1_DR  : TS_SH_DR;
         TS_EX1_DR: n = m ? TS_UPD_DR  : TS_PAU_DR;
         TS_PAU_DR: n = m ? TS_EX2_DR  : TS_PAU_DR;
         TS_EX2_DR: n = m ? TS_UPD_DR  : TS_SH_DR;
         TS_UPD_DR: n = m ? TS_SEL_DR  : TS_IDLE;
         TS_SEL_IR: n = m ? TS_RESET   : TS_CAP_IR;
         TS_CAP_IR: n = m ? TS_EX1_IR  : TS_SH_IR;
         TS_SH_IR:  n = m ? TS_EX1_IR  : TS_SH_IR;
         TS_EX1_IR: n = m ? TS_UPD_IR  : TS_PAU_IR;
         TS_PAU_IR: n = m ? TS_EX2_IR  : TS_PAU_IR;
         TS_EX2_IR: n = m ? TS_UPD_IR  : TS_SH_IR;
         TS_UPD_IR: n = m ? TS_SEL_DR  : TS_IDLE;
         default:   n = TS_RESET;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/tapbr_tap_fsm.sv
module tapbr_tap_fsm
   import tapbr_pkg::*;
(
   input  logic       tck,
   input  logic       trst_n,
   input  logic       tms,
   output tap_state_t state
);

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) state <= TS_RESET;
      else         state <= tap_next(state, tms);
   end

endmodule

// File: rtl/tapbr_sync.sv
module tapbr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("tapbr_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= d;
         end
      end else begin : g_rest
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= 1'b0;
            else        chain[g] <= chain[g-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/tapbr_bus_master.sv
module tapbr_bus_master
   import tapbr_pkg::*;
#(
   parameter int ADR_W = 30,
   parameter int DAT_W = 32,
   localparam int SEL_W = DAT_W / 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_lvl,
   input  logic             req_we,
   input  logic [ADR_W-1:0] req_adr,
   input  logic [DAT_W-1:0] req_wdat,
   output logic             wb_cyc,
   output logic             wb_stb,
   output logic             wb_we,
   output logic [ADR_W-1:0] wb_adr,
   output logic [DAT_W-1:0] wb_dat_w,
   output logic [SEL_W-1:0] wb_sel,
   input  logic [DAT_W-1:0] wb_dat_r,
   input  logic             wb_ack,
   output logic [DAT_W-1:0] rd_buf,
   output logic             done_tgl
);

   bm_state_t st;
   logic      req_seen;
   logic      new_req;

   assign new_req = req_lvl ^ req_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= BM_IDLE;
         req_seen <= 1'b0;
         wb_adr   <= '0;
         wb_dat_w <= '0;
         rd_buf   <= '0;
         done_tgl <= 1'b0;
      end else begin
         case (st)
            BM_IDLE: begin
               if (new_req) begin
                  req_seen <= req_lvl;
                  wb_adr   <= req_adr;
                  wb_dat_w <= req_wdat;
                  st       <= req_we ? BM_WRITE : BM_READ;
               end
            end
            BM_WRITE: begin
               if (wb_ack) begin
                  wb_adr <= wb_adr + 1'b1;
                  st     <= BM_READ;
               end
            end
            BM_READ: begin
               if (wb_ack) begin
                  rd_buf   <= wb_dat_r;
                  done_tgl <= ~done_tgl;
                  st       <= BM_IDLE;
               end
            end
            default: st <= BM_IDLE;
         endcase
      end
   end

   assign wb_cyc = (st != BM_IDLE);
   assign wb_stb = (st != BM_IDLE);
   assign wb_we  = (st == BM_WRITE);
   assign wb_sel = '1;

endmodule

// File: rtl/jtag_mem_bridge.sv
module jtag_mem_bridge
   import tapbr_pkg::*;
#(
   parameter int               IR_W        = 4,
   parameter int               ADR_W       = 30,
   parameter int               DAT_W       = 32,
   parameter int               SYNC_STAGES = 2,
   parameter logic [31:0]      IDCODE_VAL  = 32'h0000_18FF,
   parameter logic [IR_W-1:0]  IR_IDCODE   = 4'b0001,
   parameter logic [IR_W-1:0]  IR_MEMADR   = 4'b0101,
   parameter logic [IR_W-1:0]  IR_MEMRD    = 4'b0110,
   parameter logic [IR_W-1:0]  IR_MEMRW    = 4'b0111,
   localparam int SEL_W = DAT_W / 8
) (
   input  logic             tck,
   input  logic             trst_n,
   input  logic             tms,
   input  logic             tdi,
   output logic             tdo,
   input  logic             sys_clk,
   input  logic             sys_rst_n,
   output logic             wb_cyc,
   output logic             wb_stb,
   output logic             wb_we,
   output logic [ADR_W-1:0] wb_adr,
   output logic [DAT_W-1:0] wb_dat_w,
   output logic [SEL_W-1:0] wb_sel,
   input  logic [DAT_W-1:0] wb_dat_r,
   input  logic             wb_ack
);

   localparam int ID_W  = 32;
   localparam int MAX_A = (DAT_W > ADR_W) ? DAT_W : ADR_W;
   localparam int DR_W  = (MAX_A > ID_W) ? MAX_A : ID_W;
   localparam logic [IR_W-1:0] IR_CAPT = {{(IR_W-2){1'b0}}, 2'b01};

   if (IR_W < 2) begin : g_bad_ir
      $error("jtag_mem_bridge: IR_W must be at least 2");
   end
   if (DAT_W % 8 != 0) begin : g_bad_dat
      $error("jtag_mem_bridge: DAT_W must be a whole number of bytes");
   end
   if (ADR_W < 1) begin : g_bad_adr
      $error("jtag_mem_bridge: ADR_W must be positive");
   end

   // ---------------- controller ----------------
   tap_state_t st;

   tapbr_tap_fsm u_fsm (
      .tck    (tck),
      .trst_n (trst_n),
      .tms    (tms),
      .state  (st)
   );

   // ---------------- instruction register ----------------
   logic [IR_W-1:0] ir_sr;
   logic [IR_W-1:0] ir_q;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         ir_sr <= '0;
         ir_q  <= IR_IDCODE;
      end else begin
         case (st)
            TS_RESET:  ir_q  <= IR_IDCODE;
            TS_CAP_IR: ir_sr <= IR_CAPT;
            TS_SH_IR:  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
            TS_UPD_IR: ir_q  <= ir_sr;
            default:   ;
         endcase
      end
   end

   dr_sel_t sel;

   always_comb begin
      if      (ir_q == IR_IDCODE) sel = DR_IDENT;
      else if (ir_q == IR_MEMADR) sel = DR_ADDR;
      else if (ir_q == IR_MEMRD)  sel = DR_READ;
      else if (ir_q == IR_MEMRW)  sel = DR_SWAP;
      else                        sel = DR_BYPASS;
   end

   // ---------------- shared data shift register ----------------
   logic [DR_W-1:0]  dr_sr;
   logic [DR_W-1:0]  dr_shift;
   logic [DR_W-1:0]  dr_cap;
   logic [ADR_W-1:0] addr_q;
   logic [DAT_W-1:0] rd_buf;
   int               dr_len;

   always_comb begin
      case (sel)
         DR_IDENT:          dr_len = ID_W;
         DR_ADDR:           dr_len = ADR_W;
         DR_READ, DR_SWAP:  dr_len = DAT_W;
         default:           dr_len = 1;
      endcase
   end

   always_comb begin
      for (int i = 0; i < DR_W; i++) begin
         if (i == dr_len - 1)  dr_shift[i] = tdi;
         else if (i < DR_W - 1) dr_shift[i] = dr_sr[i+1];
         else                   dr_shift[i] = 1'b0;
      end
   end

   always_comb begin
      dr_cap = '0;
      case (sel)
         DR_IDENT:         dr_cap[ID_W-1:0]  = IDCODE_VAL;
         DR_ADDR:          dr_cap[ADR_W-1:0] = addr_q;
         DR_READ, DR_SWAP: dr_cap[DAT_W-1:0] = rd_buf;
         default:          dr_cap = '0;
      endcase
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         dr_sr <= '0;
      end else if (st == TS_CAP_DR) begin
         dr_sr <= dr_cap;
      end else if (st == TS_SH_DR) begin
         dr_sr <= dr_shift;
      end
   end

   // ---------------- request side (test clock) ----------------
   logic             req_tgl;
   logic             req_we;
   logic [ADR_W-1:0] req_adr;
   logic [DAT_W-1:0] req_wdat;
   logic             done_tgl;
   logic             done_s;
   logic             pending;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         addr_q   <= '0;
         req_tgl  <= 1'b0;
         req_we   <= 1'b0;
         req_adr  <= '0;
         req_wdat <= '0;
      end else if (st == TS_UPD_DR) begin
         case (sel)
            DR_ADDR: begin
               addr_q  <= dr_sr[ADR_W-1:0];
               req_adr <= dr_sr[ADR_W-1:0];
               req_we  <= 1'b0;
               req_tgl <= ~req_tgl;
            end
            DR_READ: begin
               addr_q  <= addr_q + 1'b1;
               req_adr <= addr_q + 1'b1;
               req_we  <= 1'b0;
               req_tgl <= ~req_tgl;
            end
            DR_SWAP: begin
               addr_q   <= addr_q + 1'b1;
               req_adr  <= addr_q;
               req_wdat <= dr_sr[DAT_W-1:0];
               req_we   <= 1'b1;
               req_tgl  <= ~req_tgl;
            end
            default: ;
         endcase
      end
   end

   tapbr_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
      .clk   (tck),
      .rst_n (trst_n),
      .d     (done_tgl),
      .q     (done_s)
   );

   assign pending = req_tgl ^ done_s;

   // ---------------- falling-edge output stage ----------------
   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) begin
         tdo <= 1'b0;
      end else begin
         case (st)
            TS_SH_DR: tdo <= dr_sr[0];
            TS_SH_IR: tdo <= ir_sr[0];
            default:  tdo <= 1'b0;
         endcase
      end
   end

   // ---------------- system side ----------------
   logic req_s;

   tapbr_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk   (sys_clk),
      .rst_n (sys_rst_n),
      .d     (req_tgl),
      .q     (req_s)
   );

   tapbr_bus_master #(.ADR_W(ADR_W), .DAT_W(DAT_W)) u_bus (
      .clk      (sys_clk),
      .rst_n    (sys_rst_n),
      .req_lvl  (req_s),
      .req_we   (req_we),
      .req_adr  (req_adr),
      .req_wdat (req_wdat),
      .wb_cyc   (wb_cyc),
      .wb_stb   (wb_stb),
      .wb_we    (wb_we),
      .wb_adr   (wb_adr),
      .wb_dat_w (wb_dat_w),
      .wb_sel   (wb_sel),
      .wb_dat_r (wb_dat_r),
      .wb_ack   (wb_ack),
      .rd_buf   (rd_buf),
      .done_tgl (done_tgl)
   );

endmodule

// File: rtl/jtag_mem_bridge_chk.sv
module jtag_mem_bridge_chk
   import tapbr_pkg::*;
#(
   parameter int              IR_W      = 4,
   parameter int              ADR_W     = 30,
   parameter logic [IR_W-1:0] IR_IDCODE = 4'b0001
) (
   input logic             tck,
   input logic             trst_n,
   input logic             tms,
   input tap_state_t       st,
   input logic [IR_W-1:0]  ir_q,
   input logic             pending,
   input logic             sys_clk,
   input logic             sys_rst_n,
   input logic             wb_cyc,
   input logic             wb_stb,
   input logic             wb_we,
   input logic [ADR_W-1:0] wb_adr,
   input logic             wb_ack
);

   logic [2:0] tms_run;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)            tms_run <= 3'd0;
      else if (!tms)          tms_run <= 3'd0;
      else if (tms_run < 3'd5) tms_run <= tms_run + 3'd1;
   end

   // R4: five high mode-select clocks always land in the reset state
   a_r4_tms_reset: assert property (@(posedge tck) disable iff (!trst_n)
      (tms_run == 3'd5) |-> (st == TS_RESET));

   // R2: leaving the reset state the identification instruction is selected
   a_r2_reset_ident: assert property (@(posedge tck) disable iff (!trst_n)
      (st == TS_RESET) |=> (ir_q == IR_IDCODE));

   // R10: no capture while a bus request is still outstanding
   a_r10_capture_settled: assert property (@(posedge tck) disable iff (!trst_n)
      (st == TS_CAP_DR) |-> !pending);

   // R10: strobe only inside a cycle
   a_r10_stb_in_cyc: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      wb_stb |-> wb_cyc);

   // R10: request held steady until acknowledged
   a_r10_hold_until_ack: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      (wb_cyc && !wb_ack) |=> (wb_cyc && $stable(wb_adr) && $stable(wb_we)));

endmodule

bind jtag_mem_bridge jtag_mem_bridge_chk #(
   .IR_W      (IR_W),
   .ADR_W     (ADR_W),
   .IR_IDCODE (IR_IDCODE)
) u_chk (
   .tck       (tck),
   .trst_n    (trst_n),
   .tms       (tms),
   .st        (st),
   .ir_q      (ir_q),
   .pending   (pending),
   .sys_clk   (sys_clk),
   .sys_rst_n (sys_rst_n),
   .wb_cyc    (wb_cyc),
   .wb_stb    (wb_stb),
   .wb_we     (wb_we),
   .wb_adr    (wb_adr),
   .wb_ack    (wb_ack)
);

// File: tb/jtag_mem_bridge_test.sv
`timescale 1ns/1ps
module jtag_mem_bridge_test;

   logic        tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
   logic        tdo;
   logic        sys_clk = 1'b0, sys_rst_n = 1'b0;
   logic        wb_cyc, wb_stb, wb_we;
   logic [29:0] wb_adr;
   logic [31:0] wb_dat_w;
   logic [3:0]  wb_sel;
   logic [31:0] wb_dat_r = '0;
   logic        wb_ack = 1'b0;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 0;

   always #2.5 sys_clk = ~sys_clk;

   jtag_mem_bridge uut (
      .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
      .sys_clk(sys_clk), .sys_rst_n(sys_rst_n),
      .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr),
      .wb_dat_w(wb_dat_w), .wb_sel(wb_sel), .wb_dat_r(wb_dat_r), .wb_ack(wb_ack)
   );

   // ---------------- reference memory and expectation queues ----------------
   logic [31:0] mem [logic [29:0]];
   logic [29:0] exp_wr_adr [$];
   logic [31:0] exp_wr_dat [$];
   logic [29:0] exp_rd_adr [$];
   int          wait_left = 0;
   int          acc_cnt   = 0;

   function automatic logic [31:0] init_word(logic [29:0] a);
      return {2'b10, a};
   endfunction

   function automatic logic [31:0] mem_rd(logic [29:0] a);
      return mem.exists(a) ? mem[a] : init_word(a);
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   always @(posedge sys_clk) begin
      if (!sys_rst_n) begin
         wb_ack    <= 1'b0;
         wait_left <= 0;
      end else if (wb_cyc && wb_stb && !wb_ack) begin
         if (wait_left == 0) begin
            wb_ack    <= 1'b1;
            wait_left <= acc_cnt % 3;
            acc_cnt   <= acc_cnt + 1;
            if (wb_we) begin
               n_tests++;
               if (exp_wr_adr.size() == 0) begin
                  n_fail++;
                  $display("FAIL R9: actual write %h@%h expected no write", wb_dat_w, wb_adr);
               end else begin
                  logic [29:0] ea;
                  logic [31:0] ed;
                  ea = exp_wr_adr.pop_front();
                  ed = exp_wr_dat.pop_front();
                  if (ea !== wb_adr || ed !== wb_dat_w) begin
                     n_fail++;
                     $display("FAIL R7: actual write %h@%h expected %h@%h", wb_dat_w, wb_adr, ed, ea);
                  end
               end
               mem[wb_adr] = wb_dat_w;
            end else begin
               n_tests++;
               if (exp_rd_adr.size() == 0) begin
                  n_fail++;
                  $display("FAIL R8: actual read @%h expected none", wb_adr);
               end else begin
                  logic [29:0] ra;
                  ra = exp_rd_adr.pop_front();
                  if (ra !== wb_adr) begin
                     n_fail++;
                     $display("FAIL R8: actual read @%h expected @%h", wb_adr, ra);
                  end
               end
               wb_dat_r <= mem_rd(wb_adr);
            end
         end else begin
            wait_left <= wait_left - 1;
         end
      end else begin
         wb_ack <= 1'b0;
      end
   end

   // ---------------- pin-level tasks ----------------
   task automatic tck_cycle(input logic m, input logic d, output logic o, input bit look);
      tms = m;
      tdi = d;
      #10;
      o = tdo;
      tck = 1'b1;
      #5;
      if (look) begin
         n_tests++;
         if (tdo !== o) begin
            n_fail++;
            $display("FAIL R11: actual tdo %b after rising edge expected %b", tdo, o);
         end
      end
      #15;
      tck = 1'b0;
      #10;
   endtask

   task automatic tap_reset();
      logic o;
      for (int i = 0; i < 5; i++) tck_cycle(1'b1, 1'b0, o, 0);
      tck_cycle(1'b0, 1'b0, o, 0);
   endtask

   task automatic shift_ir(input logic [3:0] code, output logic [3:0] cap);
      logic o;
      tck_cycle(1'b1, 1'b0, o, 0);
      tck_cycle(1'b1, 1'b0, o, 0);
      tck_cycle(1'b0, 1'b0, o, 0);
      tck_cycle(1'b0, 1'b0, o, 0);
      for (int i = 0; i < 4; i++) begin
         tck_cycle(i == 3, code[i], o, 1);
         cap[i] = o;
      end
      tck_cycle(1'b1, 1'b0, o, 0);
      tck_cycle(1'b0, 1'b0, o, 0);
   endtask

   task automatic shift_dr(input int len, input logic [31:0] din, output logic [31:0] dout);
      logic o;
      dout = '0;
      tck_cycle(1'b1, 1'b0, o, 0);
      tck_cycle(1'b0, 1'b0, o, 0);
      tck_cycle(1'b0, 1'b0, o, 0);
      for (int i = 0; i < len; i++) begin
         tck_cycle(i == len - 1, din[i], o, 1);
         dout[i] = o;
      end
      tck_cycle(1'b1, 1'b0, o, 0);
      tck_cycle(1'b0, 1'b0, o, 0);
      for (int i = 0; i < 5; i++) tck_cycle(1'b0, 1'b0, o, 0);
   endtask

   // ---------------- scenario ----------------
   initial begin
      logic [3:0]  ic;
      logic [31:0] r;
      logic        o;

      #50;
      trst_n = 1'b1;
      #20;
      chk("R1 tdo after reset", {31'd0, tdo}, 32'd0);
      chk("R1 no cycle after reset", {31'd0, wb_cyc}, 32'd0);
      tck_cycle(1'b0, 1'b0, o, 0);

      shift_dr(32, 32'hFFFF_FFFF, r);
      chk("R2 ident, system in reset", r, 32'h0000_18FF);
      shift_dr(32, 32'h1234_5678, r);
      chk("R2 ident repeated", r, 32'h0000_18FF);
      sys_rst_n = 1'b1;
      shift_dr(32, 32'h0, r);
      chk("R2 ident, system running", r, 32'h0000_18FF);
      chk("R1 tdo idle", {31'd0, tdo}, 32'd0);

      shift_ir(4'b1111, ic);
      chk("R3 ir capture", {28'd0, ic}, 32'h1);
      shift_dr(8, 32'hB3, r);
      chk("R5 bypass delay", r, 32'h66);

      tap_reset();
      shift_dr(32, 32'h0, r);
      chk("R4 ident after tms reset", r, 32'h0000_18FF);

      shift_ir(4'b0010, ic);
      shift_dr(8, 32'h5A, r);
      chk("R5 unknown code bypass", r, 32'hB4);

      // address load and swap sequence
      shift_ir(4'b0101, ic);
      exp_rd_adr.push_back(30'd1);
      shift_dr(30, 32'd1, r);
      chk("R6 address capture", r, 32'd0);

      shift_ir(4'b0111, ic);
      exp_wr_adr.push_back(30'd1); exp_wr_dat.push_back(32'h5555_5555); exp_rd_adr.push_back(30'd2);
      shift_dr(32, 32'h5555_5555, r);
      chk("R7 swap returns stored word", r, init_word(30'd1));
      exp_wr_adr.push_back(30'd2); exp_wr_dat.push_back(32'hAAAA_AAAA); exp_rd_adr.push_back(30'd3);
      shift_dr(32, 32'hAAAA_AAAA, r);
      chk("R8 next word after swap", r, init_word(30'd2));

      shift_ir(4'b0101, ic);
      exp_rd_adr.push_back(30'd1);
      shift_dr(30, 32'd1, r);
      chk("R8 address advanced twice", r, 32'd3);

      shift_ir(4'b0111, ic);
      exp_wr_adr.push_back(30'd1); exp_wr_dat.push_back(32'hAAAA_AAAA); exp_rd_adr.push_back(30'd2);
      shift_dr(32, 32'hAAAA_AAAA, r);
      chk("R7 swap sees prior write", r, 32'h5555_5555);
      exp_wr_adr.push_back(30'd2); exp_wr_dat.push_back(32'h5555_5555); exp_rd_adr.push_back(30'd3);
      shift_dr(32, 32'h5555_5555, r);
      chk("R7 swap second word", r, 32'hAAAA_AAAA);

      // read-only streaming
      shift_ir(4'b0101, ic);
      exp_rd_adr.push_back(30'd1);
      shift_dr(30, 32'd1, r);
      shift_ir(4'b0110, ic);
      exp_rd_adr.push_back(30'd2);
      shift_dr(32, 32'h1234_5678, r);
      chk("R9 read stored word", r, 32'hAAAA_AAAA);
      exp_rd_adr.push_back(30'd3);
      shift_dr(32, 32'hFFFF_0000, r);
      chk("R9 read next word", r, 32'h5555_5555);
      shift_ir(4'b0101, ic);
      exp_rd_adr.push_back(30'd1);
      shift_dr(30, 32'd1, r);
      shift_ir(4'b0110, ic);
      exp_rd_adr.push_back(30'd2);
      shift_dr(32, 32'h0, r);
      chk("R9 input bits not written", r, 32'hAAAA_AAAA);

      // address wrap
      shift_ir(4'b0101, ic);
      exp_rd_adr.push_back(30'h3FFF_FFFF);
      shift_dr(30, 32'h3FFF_FFFF, r);
      shift_ir(4'b0110, ic);
      exp_rd_adr.push_back(30'd0);
      shift_dr(32, 32'h0, r);
      chk("R8 top word", r, init_word(30'h3FFF_FFFF));
      exp_rd_adr.push_back(30'd1);
      shift_dr(32, 32'h0, r);
      chk("R8 wrapped to word zero", r, init_word(30'd0));
      shift_ir(4'b0101, ic);
      exp_rd_adr.push_back(30'd0);
      shift_dr(30, 32'd0, r);
      chk("R8 address after wrap", r, 32'd1);

      #200;
      chk("R8 all reads seen", exp_rd_adr.size(), 32'd0);
      chk("R7 all writes seen", exp_wr_adr.size(), 32'd0);
      chk("R1 tdo idle at end", {31'd0, tdo}, 32'd0);

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #500us;
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule